// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is the control sequencer of a 16-bit, word-addressed processor. It moves every instruction through a fixed series of phases. First it reads the instruction word and advances the program counter. Then it decodes the opcode, latches the effective address, and optionally follows a pointer word. It then gathers operands and executes. A final write-back phase runs only when the instruction produces a result. The block holds the program counter, the instruction register and the memory address and data registers. All of its memory traffic goes through one request/ready port. When the memory is slow, the block waits in place for as many cycles as needed.

An external address unit supplies the effective address on `ea_i`, and an external condition unit supplies the branch decision on `br_taken_i`. The register file provides the store data on `st_data_i`. The sequencer drives the ALU enable, the register-file write enable and a write-source select. The source choices are the ALU result, the memory data register, the memory address register, or the incremented program counter used as a link. A service trap with vector 0x25 stops sequencing and keeps a halted flag raised until reset.

Top module: `instr_seq`

## Requirements
- R1: After reset the phase is fetch (code 0), the PC and the address on `mem_addr_o` equal the `RESET_PC` parameter (default 0x3000), and `halted_o` is low.
- R2: Phase codes are fetch 0, decode 1, address 2, pointer 3, operand 4, execute 5, write-back 6, halted 7. With zero wait states, an instruction takes 5 cycles without write-back and 6 cycles with it, and the pointer phase adds 1 more. Write-back is the only phase that asserts `rf_we_o` or `mem_we_o`.
- R3: Fetch reads the word at the PC into `ir_o`, and on completion the PC becomes the fetch address plus one. Later phases see this incremented PC.
- R4: Every access uses `mar_o` as its address and `mdr_o` as its write data. The effective address `ea_i` is loaded into the address register in the address phase.
- R5: A request, with its address, write enable and write data, is held stable until `mem_ready_i` is high. Each wait cycle lengthens the instruction by exactly one cycle.
- R6: The indirect load (opcode 1010) and indirect store (opcode 1011) first read a pointer word at `ea_i`, then access memory at that pointer.
- R7: The loads (opcodes 0010, 0110, 1010) write the register file with source 1 (memory data). The address-load (opcode 1110) writes with source 2 (address register). The operate opcodes 0001, 0101 and 1001 pulse `alu_en_o` in execute and write with source 0 (ALU).
- R8: The stores (opcodes 0011, 0111, 1011) write the value of `st_data_i` sampled in the operand phase, and never assert `rf_we_o`.
- R9: A branch (opcode 0000) moves the PC to `ea_i` only when `br_taken_i` is high. A jump (opcode 1100) always moves it there. Neither has a write-back phase.
- R10: A subroutine call (opcode 0100) and a trap (opcode 1111) write the incremented PC with source 3. The call then continues at `ea_i`, and the trap continues at the word read from `ea_i`.
- R11: A trap whose low 8 bits are 0x25 enters the halted phase straight after decode. `halted_o` then stays high, no request or register write is made, and the PC stays frozen until reset.
- R12: Opcodes 1000 and 1101 take 5 cycles with no register write, no memory write and no ALU enable, and the PC advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data |
| mem_ready_i | input | 1 | Memory completes the current request |
| ea_i | input | 16 | Effective address from the address unit |
| br_taken_i | input | 1 | Branch condition met |
| st_data_i | input | 16 | Register value to store |
| ir_o | output | 16 | Instruction register |
| pc_o | output | 16 | Program counter |
| mar_o | output | 16 | Memory address register |
| mdr_o | output | 16 | Memory data register |
| phase_o | output | 3 | Current phase code |
| alu_en_o | output | 1 | ALU enable |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wsrc_o | output | 2 | Register write source: 0 ALU, 1 MDR, 2 MAR, 3 PC |
| halted_o | output | 1 | Sequencing stopped by halt trap |

## Verification
The assertions assume that the memory returns read data in the same cycle as `mem_ready_i`. They also assume that `ea_i`, `br_taken_i` and `st_data_i` stay stable for the whole instruction that uses them. The bench keeps to this: its memory model is combinational and raises ready after a programmable number of wait cycles, and each input is set before the instruction word is placed in memory and held until the next fetch. Halt and reset are applied only at phase boundaries seen from the ports.

// File: rtl/instr_seq_pkg.sv
package instr_seq_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EVAL   = 3'd2,
    PH_IND    = 3'd3,
    PH_OPER   = 3'd4,
    PH_EXEC   = 3'd5,
    PH_STORE  = 3'd6,
    PH_HALT   = 3'd7
  } phase_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'd0,
    WB_MDR = 2'd1,
    WB_MAR = 2'd2,
    WB_PC  = 2'd3
  } wb_src_e;

  typedef struct packed {
    logic    rd_oper;
    logic    ind;
    logic    mem_wr;
    logic    rf_wr;
    wb_src_e wsrc;
    logic    alu;
    logic    cond_br;
    logic    jmp;
    logic    link;
    logic    trap;
  } attr_t;
endpackage

// File: rtl/instr_seq_decode.sv
module instr_seq_decode
  import instr_seq_pkg::*;
#(
  parameter int          VEC_W    = 8,
  parameter logic [7:0]  HALT_VEC = 8'h25
) (
  input  logic [OPC_W-1:0] opc_i,
  input  logic [VEC_W-1:0] vec_i,
  output attr_t            attr_o,
  output logic             halt_o
);
  always_comb begin
    attr_o = '0;
    attr_o.wsrc = WB_ALU;
    unique case (opc_i)
      4'b0001, 4'b0101, 4'b1001: begin
        attr_o.alu = 1'b1; attr_o.rf_wr = 1'b1;
      end
      4'b0010, 4'b0110: begin
        attr_o.rd_oper = 1'b1; attr_o.rf_wr = 1'b1; attr_o.wsrc = WB_MDR;
      end
      4'b1010: begin
        attr_o.ind = 1'b1; attr_o.rd_oper = 1'b1; attr_o.rf_wr = 1'b1; attr_o.wsrc = WB_MDR;
      end
      4'b0011, 4'b0111: attr_o.mem_wr = 1'b1;
      4'b1011: begin
        attr_o.ind = 1'b1; attr_o.mem_wr = 1'b1;
      end
      4'b1110: begin
        attr_o.rf_wr = 1'b1; attr_o.wsrc = WB_MAR;
      end
      4'b0000: attr_o.cond_br = 1'b1;
      4'b1100: attr_o.jmp = 1'b1;
      4'b0100: begin
        attr_o.link = 1'b1; attr_o.rf_wr = 1'b1; attr_o.wsrc = WB_PC;
      end
      4'b1111: begin
        attr_o.trap = 1'b1; attr_o.rd_oper = 1'b1; attr_o.rf_wr = 1'b1; attr_o.wsrc = WB_PC;
      end
      default: ;
    endcase
  end

  assign halt_o = attr_o.trap && (vec_i == HALT_VEC[VEC_W-1:0]);
endmodule

// File: rtl/instr_seq_ctrl.sv
module instr_seq_ctrl
  import instr_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rd_oper_i,
  input  logic    ind_i,
  input  logic    mem_wr_i,
  input  logic    rf_wr_i,
  input  wb_src_e wsrc_i,
  input  logic    alu_i,
  input  logic    halt_i,
  input  logic    mem_ready_i,
  output phase_e  phase_o,
  output logic    step_o,
  output logic    fin_o,
  output logic    mem_req_o,
  output logic    mem_we_o,
  output logic    alu_en_o,
  output logic    rf_we_o,
  output wb_src_e rf_wsrc_o,
  output logic    halted_o
);
  phase_e ph_q, ph_d;
  logic   has_wb;

  assign has_wb = rf_wr_i | mem_wr_i;

  assign mem_req_o = (ph_q == PH_FETCH) || (ph_q == PH_IND) ||
                     ((ph_q == PH_OPER) && rd_oper_i) ||
                     ((ph_q == PH_STORE) && mem_wr_i);
  assign mem_we_o  = (ph_q == PH_STORE) && mem_wr_i;
  assign step_o    = !mem_req_o || mem_ready_i;
  assign fin_o     = step_o && (((ph_q == PH_EXEC) && !has_wb) || (ph_q == PH_STORE));

  always_comb begin
    ph_d = ph_q;
    if (step_o) begin
      unique case (ph_q)
        PH_FETCH:  ph_d = PH_DECODE;
        PH_DECODE: ph_d = halt_i ? PH_HALT : PH_EVAL;
        PH_EVAL:   ph_d = ind_i ? PH_IND : PH_OPER;
        PH_IND:    ph_d = PH_OPER;
        PH_OPER:   ph_d = PH_EXEC;
        PH_EXEC:   ph_d = has_wb ? PH_STORE : PH_FETCH;
        PH_STORE:  ph_d = PH_FETCH;
        PH_HALT:   ph_d = PH_HALT;
        default:   ph_d = PH_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_FETCH;
    else         ph_q <= ph_d;
  end

  assign phase_o   = ph_q;
  assign alu_en_o  = (ph_q == PH_EXEC) && alu_i;
  assign rf_we_o   = (ph_q == PH_STORE) && rf_wr_i;
  assign rf_wsrc_o = wsrc_i;
  assign halted_o  = (ph_q == PH_HALT);
endmodule

// File: rtl/instr_seq_regs.sv
module instr_seq_regs
  import instr_seq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic          step_i,
  input  logic          fin_i,
  input  logic          rd_oper_i,
  input  logic          mem_wr_i,
  input  logic          cond_br_i,
  input  logic          jmp_i,
  input  logic          link_i,
  input  logic          trap_i,
  input  logic          br_taken_i,
  input  logic [DW-1:0] ea_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] st_data_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] mar_o,
  output logic [DW-1:0] mdr_o
);
  localparam logic [DW-1:0] PC_RST = DW'(RESET_PC);

  logic [DW-1:0] pc_q, ir_q, mar_q, mdr_q, pc_nxt;

  // redirect lands when the instruction completes
  always_comb begin
    pc_nxt = pc_q;
    if (phase_i == PH_EXEC && (jmp_i || (cond_br_i && br_taken_i))) pc_nxt = mar_q;
    if (phase_i == PH_STORE && link_i) pc_nxt = mar_q;
    if (phase_i == PH_STORE && trap_i) pc_nxt = mdr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= PC_RST;
      mar_q <= PC_RST;
      ir_q  <= '0;
      mdr_q <= '0;
    end else if (step_i) begin
      unique case (phase_i)
        PH_FETCH: begin
          ir_q  <= rdata_i;
          mdr_q <= rdata_i;
          pc_q  <= pc_q + DW'(1);
        end
        PH_EVAL: mar_q <= ea_i;
        PH_IND: begin
          mar_q <= rdata_i;
          mdr_q <= rdata_i;
        end
        PH_OPER: begin
          if (rd_oper_i)     mdr_q <= rdata_i;
          else if (mem_wr_i) mdr_q <= st_data_i;
        end
        default: ;
      endcase
      if (fin_i) begin
        pc_q  <= pc_nxt;
        mar_q <= pc_nxt;
      end
    end
  end

  assign pc_o  = pc_q;
  assign ir_o  = ir_q;
  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
endmodule

// File: rtl/instr_seq.sv
module instr_seq
  import instr_seq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter logic [15:0] RESET_PC = 16'h3000,
  parameter int          VEC_W    = 8,
  parameter logic [7:0]  HALT_VEC = 8'h25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] ea_i,
  input  logic          br_taken_i,
  input  logic [DW-1:0] st_data_i,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] mar_o,
  output logic [DW-1:0] mdr_o,
  output logic [2:0]    phase_o,
  output logic          alu_en_o,
  output logic          rf_we_o,
  output logic [1:0]    rf_wsrc_o,
  output logic          halted_o
);
  localparam int OPC_LSB = DW - OPC_W;

  attr_t         attr;
  logic          halt_req, step, fin;
  phase_e        phase;
  wb_src_e       wsrc;
  logic [DW-1:0] ir, mar, mdr;

  instr_seq_decode #(.VEC_W(VEC_W), .HALT_VEC(HALT_VEC)) u_dec (
    .opc_i  (ir[DW-1:OPC_LSB]),
    .vec_i  (ir[VEC_W-1:0]),
    .attr_o (attr),
    .halt_o (halt_req)
  );

  instr_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_oper_i   (attr.rd_oper),
    .ind_i       (attr.ind),
    .mem_wr_i    (attr.mem_wr),
    .rf_wr_i     (attr.rf_wr),
    .wsrc_i      (attr.wsrc),
    .alu_i       (attr.alu),
    .halt_i      (halt_req),
    .mem_ready_i (mem_ready_i),
    .phase_o     (phase),
    .step_o      (step),
    .fin_o       (fin),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .alu_en_o    (alu_en_o),
    .rf_we_o     (rf_we_o),
    .rf_wsrc_o   (wsrc),
    .halted_o    (halted_o)
  );

  instr_seq_regs #(.DW(DW), .RESET_PC(RESET_PC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase),
    .step_i     (step),
    .fin_i      (fin),
    .rd_oper_i  (attr.rd_oper),
    .mem_wr_i   (attr.mem_wr),
    .cond_br_i  (attr.cond_br),
    .jmp_i      (attr.jmp),
    .link_i     (attr.link),
    .trap_i     (attr.trap),
    .br_taken_i (br_taken_i),
    .ea_i       (ea_i),
    .rdata_i    (mem_rdata_i),
    .st_data_i  (st_data_i),
    .pc_o       (pc_o),
    .ir_o       (ir),
    .mar_o      (mar),
    .mdr_o      (mdr)
  );

  assign ir_o        = ir;
  assign mar_o       = mar;
  assign mdr_o       = mdr;
  assign mem_addr_o  = mar;
  assign mem_wdata_o = mdr;
  assign phase_o     = phase;
  assign rf_wsrc_o   = wsrc;
endmodule

// File: rtl/instr_seq_chk.sv
module instr_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i,
  input logic [DW-1:0] pc_o,
  input logic [2:0]    phase_o,
  input logic          alu_en_o,
  input logic          rf_we_o,
  input logic          halted_o
);
  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_wdata_o)));

  a_r3_pc_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0 && mem_ready_i) |=> (pc_o == $past(pc_o) + DW'(1)));

  a_r2_decode_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o == 3'd1) |-> ($past(phase_o) == 3'd0));

  a_r2_writes_in_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o || mem_we_o) |-> (phase_o == 3'd6));

  a_r8_store_no_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !rf_we_o);

  a_r11_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!mem_req_o && !rf_we_o && !alu_en_o));

  a_r11_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o)));
endmodule

bind instr_seq instr_seq_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .pc_o        (pc_o),
  .phase_o     (phase_o),
  .alu_en_o    (alu_en_o),
  .rf_we_o     (rf_we_o),
  .halted_o    (halted_o)
);

// File: tb/tb_instr_seq.sv
module tb_instr_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_req_o, mem_we_o, mem_ready_i;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [15:0] ea_i = '0, st_data_i = '0;
  logic        br_taken_i = 1'b0;
  logic [15:0] ir_o, pc_o, mar_o, mdr_o;
  logic [2:0]  phase_o;
  logic        alu_en_o, rf_we_o, halted_o;
  logic [1:0]  rf_wsrc_o;

  int checks = 0;
  int errors = 0;
  int wait_n = 0;
  int wcnt = 0;
  logic [15:0] mem [256];

  always #4 clk_i = ~clk_i;

  instr_seq dut (.*);

  assign mem_rdata_i = mem[mem_addr_o[7:0]];
  assign mem_ready_i = mem_req_o && (wcnt >= wait_n);

  always @(posedge clk_i) begin
    if (mem_req_o && !mem_ready_i) wcnt <= wcnt + 1;
    else                           wcnt <= 0;
  end

  typedef struct packed {
    logic [15:0] instr;
    logic [15:0] ea;
    logic [15:0] st;
    logic [15:0] ptr;
    logic [15:0] dat;
    logic        br;
    logic [3:0]  cyc;
    logic [1:0]  nacc;
    logic [2:0]  wsrc;   // 4: no register write
    logic        memwr;
    logic        alu;
    logic [1:0]  npc;    // 0 pc+1, 1 ea, 2 word at ea
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{16'h1261, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd6, 2'd1, 3'd0, 1'b0, 1'b1, 2'd0}, // R7 add
    '{16'h56E0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd6, 2'd1, 3'd0, 1'b0, 1'b1, 2'd0}, // R7 and
    '{16'h927F, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd6, 2'd1, 3'd0, 1'b0, 1'b1, 2'd0}, // R7 not
    '{16'h2802, 16'h30C0, 16'h0000, 16'h0000, 16'hBEEF, 1'b0, 4'd6, 2'd2, 3'd1, 1'b0, 1'b0, 2'd0}, // R7 ld
    '{16'h6840, 16'h30C1, 16'h0000, 16'h0000, 16'h1234, 1'b0, 4'd6, 2'd2, 3'd1, 1'b0, 1'b0, 2'd0}, // R7 ldr
    '{16'hA802, 16'h30C2, 16'h0000, 16'h30C8, 16'h5A5A, 1'b0, 4'd7, 2'd3, 3'd1, 1'b0, 1'b0, 2'd0}, // R6 ldi
    '{16'h3802, 16'h30C3, 16'hCAFE, 16'h0000, 16'h0000, 1'b0, 4'd6, 2'd2, 3'd4, 1'b1, 1'b0, 2'd0}, // R8 st
    '{16'h7840, 16'h30C4, 16'h0F0F, 16'h0000, 16'h0000, 1'b0, 4'd6, 2'd2, 3'd4, 1'b1, 1'b0, 2'd0}, // R8 str
    '{16'hB802, 16'h30C5, 16'h7777, 16'h30C9, 16'h0000, 1'b0, 4'd7, 2'd3, 3'd4, 1'b1, 1'b0, 2'd0}, // R6 sti
    '{16'hE2FF, 16'h3100, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd6, 2'd1, 3'd2, 1'b0, 1'b0, 2'd0}, // R7 lea
    '{16'h0405, 16'h3044, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd5, 2'd1, 3'd4, 1'b0, 1'b0, 2'd0}, // R9 br not taken
    '{16'h0FFA, 16'h3044, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd5, 2'd1, 3'd4, 1'b0, 1'b0, 2'd1}, // R9 br taken
    '{16'hC1C0, 16'h3048, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd5, 2'd1, 3'd4, 1'b0, 1'b0, 2'd1}, // R9 jmp
    '{16'h4805, 16'h3050, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd6, 2'd1, 3'd3, 1'b0, 1'b0, 2'd1}, // R10 call
    '{16'hF023, 16'h00A3, 16'h0000, 16'h3058, 16'h0000, 1'b0, 4'd6, 2'd2, 3'd3, 1'b0, 1'b0, 2'd2}, // R10 trap
    '{16'h8000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd5, 2'd1, 3'd4, 1'b0, 1'b0, 2'd0}, // R12
    '{16'hD000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd5, 2'd1, 3'd4, 1'b0, 1'b0, 2'd0}  // R12
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int w);
    logic [15:0] pc0, wval, waddr, wdat, exp_pc, exp_wval;
    bit          left, rf_seen, mw_seen;
    logic [1:0]  wsrc_seen;
    int          cyc, alu_n;
    pc0 = pc_o;
    if (v.ptr != 16'h0) begin
      mem[v.ea[7:0]]  = v.ptr;
      mem[v.ptr[7:0]] = v.dat;
    end else begin
      mem[v.ea[7:0]] = v.dat;
    end
    mem[pc0[7:0]] = v.instr;
    ea_i = v.ea; br_taken_i = v.br; st_data_i = v.st;
    left = 0; rf_seen = 0; mw_seen = 0; cyc = 0; alu_n = 0;
    wval = '0; waddr = '0; wdat = '0; wsrc_seen = '0;
    while (!(left && phase_o == 3'd0) && cyc < 60) begin
      if (rf_we_o) begin
        rf_seen = 1; wsrc_seen = rf_wsrc_o;
        case (rf_wsrc_o)
          2'd1: wval = mdr_o;
          2'd2: wval = mar_o;
          2'd3: wval = pc_o;
          default: wval = '0;
        endcase
      end
      if (alu_en_o) alu_n++;
      if (mem_req_o && mem_we_o && mem_ready_i) begin
        mw_seen = 1; waddr = mem_addr_o; wdat = mem_wdata_o;
        mem[mem_addr_o[7:0]] = mem_wdata_o;
      end
      @(posedge clk_i); @(negedge clk_i);
      cyc++;
      if (phase_o != 3'd0) left = 1;
    end
    check("R2/R5 cycle count", 16'(cyc), 16'(int'(v.cyc) + w * int'(v.nacc)));
    check("R3 fetched word", ir_o, v.instr);
    case (v.npc)
      2'd1:    exp_pc = v.ea;
      2'd2:    exp_pc = v.ptr;
      default: exp_pc = pc0 + 16'd1;
    endcase
    check("R9/R10/R3 next pc", pc_o, exp_pc);
    check("R4 next fetch address", mem_addr_o, exp_pc);
    check("R7/R8/R12 register write seen", 16'(rf_seen), 16'(v.wsrc != 3'd4));
    if (v.wsrc != 3'd4) begin
      check("R7/R10 write source", 16'(wsrc_seen), 16'(v.wsrc));
      case (v.wsrc)
        3'd1:    exp_wval = (v.ptr != 16'h0) ? v.dat : v.dat;
        3'd2:    exp_wval = v.ea;
        3'd3:    exp_wval = pc0 + 16'd1;
        default: exp_wval = wval;
      endcase
      check("R7/R10 write value", wval, exp_wval);
    end
    check("R8/R12 memory write seen", 16'(mw_seen), 16'(v.memwr));
    if (v.memwr) begin
      check("R6/R8 write address", waddr, (v.ptr != 16'h0) ? v.ptr : v.ea);
      check("R8 write data", wdat, v.st);
    end
    check("R7/R12 alu enable count", 16'(alu_n), 16'(v.alu));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    logic [15:0] pch;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    do_reset();
    // R1 reset state (one fetch cycle has passed with data 0 pending? no: check before release edge)
    rst_ni = 1'b0;
    #1;
    check("R1 phase", 16'(phase_o), 16'd0);
    check("R1 pc", pc_o, 16'h3000);
    check("R1 address", mem_addr_o, 16'h3000);
    check("R1 halted", 16'(halted_o), 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int pass = 0; pass < 2; pass++) begin
      wait_n = pass * 2;
      for (int k = 0; k < NV; k++) run_vec(VT[k], wait_n);
    end

    // R5 wait state holds the request at the same address
    wait_n = 3;
    pch = pc_o;
    mem[pch[7:0]] = 16'h1261;
    @(posedge clk_i); @(negedge clk_i);
    check("R5 request held", 16'(mem_req_o), 16'd1);
    check("R5 address held", mem_addr_o, pch);
    check("R5 still in fetch", 16'(phase_o), 16'd0);
    repeat (8) @(negedge clk_i);
    wait_n = 0;
    while (phase_o != 3'd0) @(negedge clk_i);

    // R11 halt trap
    pch = pc_o;
    mem[pch[7:0]] = 16'hF025;
    repeat (2) @(negedge clk_i);
    check("R11 halted phase", 16'(phase_o), 16'd7);
    check("R11 halted flag", 16'(halted_o), 16'd1);
    check("R11 pc after halt", pc_o, pch + 16'd1);
    repeat (20) @(negedge clk_i);
    check("R11 still halted", 16'(halted_o), 16'd1);
    check("R11 pc frozen", pc_o, pch + 16'd1);
    check("R11 no request", 16'(mem_req_o), 16'd0);
    check("R11 no register write", 16'(rf_we_o), 16'd0);

    // R1 reset leaves halt
    do_reset();
    check("R1 halt cleared", 16'(halted_o), 16'd0);
    check("R1 pc after reset", pc_o[15:8], 16'h0030);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule